// File: doc/BRIEF.md
# I2C Status Flags with Clock Stretching

This block keeps the four status flags of an I2C controller that software polls or takes interrupts on: a start-generated flag, a master-mode flag, an address-hit flag and a byte-done flag. The serial engine reports bus events to it as one-cycle pulses, and the CPU-side register interface reports reads of the status register and reads or writes of the data register. From these the block sets and clears the flags. It drives an interrupt request and a request to hold the serial clock low while software still owes the bus a response.

Software clears a flag by reading the status register and then accessing the data register. A status read sets an internal arm bit. A data-register access only clears a flag while that bit is set. Every data access clears the arm bit. A read alone is enough to clear the address-hit flag. Dropping the peripheral enable clears all flags at once.

Top module: `i2c_stat_flags`

## Requirements
- R1: The status output carries byte-done at bit 3, address-hit at bit 2, master-mode at bit 1 and start-generated at bit 0. After reset, status is 0 and both irq and scl_hold are 0.
- R2: Start-generated sets on the edge that samples ev_start_done. It clears only on an armed wr_data.
- R3: Master-mode sets on the edge that samples start_req. It clears on the edge that samples ev_stop or ev_arb_lost.
- R4: Address-hit sets on ev_addr_match or ev_gen_call. It clears on rd_status alone, with no data access needed.
- R5: In transmit, byte-done sets on ev_ack_tx while in_addr_phase is 0, and on ev_addr_done. An ev_ack_tx during the address phase does not set it. A transmit byte-done clears on an armed wr_data and not on rd_data.
- R6: In receive, byte-done sets on ev_ack_rx only while ack_en is 1. A receive byte-done clears on an armed rd_data and not on wr_data.
- R7: rd_status arms the clear sequence and any rd_data or wr_data disarms it. An unarmed data access clears no flag.
- R8: scl_hold is 1 exactly while byte-done or address-hit is 1.
- R9: While enable is 0, every flag and the arm bit are 0 after the next edge, and set events are ignored.
- R10: irq is registered and goes to 1 on the edge after a cycle with irq_en=1 and any of start-generated, address-hit or byte-done set. Master-mode alone never raises irq.
- R11: When a set event and a clear condition for the same flag occur in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 clears all flags |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| in_addr_phase | input | 1 | The byte being sent is the address byte |
| start_req | input | 1 | Software requests a START (pulse) |
| ev_start_done | input | 1 | START condition generated (pulse) |
| ev_stop | input | 1 | STOP condition detected (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_addr_match | input | 1 | Received address equals own address (pulse) |
| ev_gen_call | input | 1 | General call recognised (pulse) |
| ev_ack_tx | input | 1 | Acknowledge clock received after a sent byte (pulse) |
| ev_addr_done | input | 1 | Address phase complete after the address byte (pulse) |
| ev_ack_rx | input | 1 | Acknowledge clock sent after a received byte (pulse) |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_data | input | 1 | Data register write strobe |
| status | output | 4 | Flags: [3] byte-done, [2] address-hit, [1] master-mode, [0] start-generated |
| scl_hold | output | 1 | Hold the serial clock low |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences run each flag through its own clear path. They contrast an armed access with an unarmed one, and a write with a read for each transfer direction, so a swapped direction or a missing arm check shows up as a flag that stays set or clears too early. Further cases put set and clear in the same cycle, send an acknowledge during the address phase, and receive with acknowledge disabled. Seeded random traffic then mixes events, register strobes and enable drops against a cycle model in the bench, which exposes wrong priorities between kill, set and clear and an irq that is not registered.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned NFLAG   = 4;
  localparam int unsigned IDX_SB  = 0;
  localparam int unsigned IDX_MSL = 1;
  localparam int unsigned IDX_ADR = 2;
  localparam int unsigned IDX_BTF = 3;
  // flags that may raise the interrupt
  localparam logic [NFLAG-1:0] IRQ_SRC_MASK = 4'b1101;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_stat_flag_cell.sv
module i2c_stat_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (kill)      q_d = 1'b0;
    else if (set)  q_d = 1'b1;
    else if (clr)  q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/i2c_stat_arm.sv
module i2c_stat_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic rd_status,
  input  logic data_acc,
  output logic armed
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (kill)           arm_d = 1'b0;
    else if (rd_status) arm_d = 1'b1;
    else if (data_acc)  arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign armed = arm_q;
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] SRC_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_en,
  input  logic [W-1:0] pend,
  output logic         irq
);
  logic irq_q, irq_d;

  always_comb irq_d = irq_en & (|(pend & SRC_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             irq_en,
  input  logic             ack_en,
  input  logic             in_addr_phase,
  input  logic             start_req,
  input  logic             ev_start_done,
  input  logic             ev_stop,
  input  logic             ev_arb_lost,
  input  logic             ev_addr_match,
  input  logic             ev_gen_call,
  input  logic             ev_ack_tx,
  input  logic             ev_addr_done,
  input  logic             ev_ack_rx,
  input  logic             rd_status,
  input  logic             rd_data,
  input  logic             wr_data,
  output logic [NFLAG-1:0] status,
  output logic             scl_hold,
  output logic             irq
);
  logic      kill;
  logic      armed;
  flag_vec_t set_v, clr_v, flag_q;
  logic      btf_tx_set, btf_rx_set;
  logic      dir_rx_q, dir_rx_d;

  assign kill = ~enable;

  // byte-done sources per direction
  always_comb begin
    btf_tx_set = (ev_ack_tx & ~in_addr_phase) | ev_addr_done;
    btf_rx_set = ev_ack_rx & ack_en;
  end

  // set and clear requests per flag
  always_comb begin
    set_v          = '0;
    clr_v          = '0;
    set_v[IDX_SB]  = ev_start_done;
    clr_v[IDX_SB]  = armed & wr_data;
    set_v[IDX_MSL] = start_req;
    clr_v[IDX_MSL] = ev_stop | ev_arb_lost;
    set_v[IDX_ADR] = ev_addr_match | ev_gen_call;
    clr_v[IDX_ADR] = rd_status;
    set_v[IDX_BTF] = btf_tx_set | btf_rx_set;
    clr_v[IDX_BTF] = armed & (dir_rx_q ? rd_data : wr_data);
  end

  // direction of the pending byte-done flag
  always_comb begin
    dir_rx_d = dir_rx_q;
    if (kill)            dir_rx_d = 1'b0;
    else if (btf_rx_set) dir_rx_d = 1'b1;
    else if (btf_tx_set) dir_rx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_rx_q <= 1'b0;
    else        dir_rx_q <= dir_rx_d;
  end

  i2c_stat_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .rd_status (rd_status),
    .data_acc  (rd_data | wr_data),
    .armed     (armed)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    i2c_stat_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (kill),
      .set   (set_v[g]),
      .clr   (clr_v[g]),
      .q     (flag_q[g])
    );
  end

  i2c_stat_irq #(
    .W        (NFLAG),
    .SRC_MASK (IRQ_SRC_MASK)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_en (irq_en),
    .pend   (flag_q),
    .irq    (irq)
  );

  assign status   = flag_q;
  assign scl_hold = flag_q[IDX_BTF] | flag_q[IDX_ADR];
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       irq_en,
  input logic       ack_en,
  input logic       start_req,
  input logic       ev_start_done,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       ev_addr_match,
  input logic       ev_gen_call,
  input logic       ev_ack_tx,
  input logic       ev_addr_done,
  input logic       ev_ack_rx,
  input logic       rd_status,
  input logic [3:0] status,
  input logic       scl_hold,
  input logic       irq
);
  // R2
  sb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_start_done |=> status[0]);
  // R3
  msl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && start_req |=> status[1]);
  // R3
  msl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && (ev_stop || ev_arb_lost) && !start_req |=> !status[1]);
  // R4
  adsl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && rd_status && !ev_addr_match && !ev_gen_call |=> !status[2]);
  // R6
  btf_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] && ev_ack_rx && !ack_en && !ev_ack_tx && !ev_addr_done |=> !status[3]);
  // R8
  scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold == (status[3] || status[2]));
  // R9
  kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> status == 4'b0000);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en && (status[0] || status[2] || status[3]) |=> irq);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .irq_en        (irq_en),
  .ack_en        (ack_en),
  .start_req     (start_req),
  .ev_start_done (ev_start_done),
  .ev_stop       (ev_stop),
  .ev_arb_lost   (ev_arb_lost),
  .ev_addr_match (ev_addr_match),
  .ev_gen_call   (ev_gen_call),
  .ev_ack_tx     (ev_ack_tx),
  .ev_addr_done  (ev_addr_done),
  .ev_ack_rx     (ev_ack_rx),
  .rd_status     (rd_status),
  .status        (status),
  .scl_hold      (scl_hold),
  .irq           (irq)
);

// File: tb/sim_i2c_stat_flags.sv
`timescale 1ns/1ps
module sim_i2c_stat_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, irq_en = 1'b0, ack_en = 1'b0, in_addr_phase = 1'b0;
  logic start_req = 1'b0, ev_start_done = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0;
  logic ev_addr_match = 1'b0, ev_gen_call = 1'b0, ev_ack_tx = 1'b0, ev_addr_done = 1'b0;
  logic ev_ack_rx = 1'b0, rd_status = 1'b0, rd_data = 1'b0, wr_data = 1'b0;
  logic [3:0] status;
  logic scl_hold, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model state
  bit m_sb, m_msl, m_adr, m_btf, m_rx, m_arm, m_irq;

  always #10 clk = ~clk;

  i2c_stat_flags u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit txs, rxs, sb_c, btf_c, arm_n;
    m_irq = irq_en & (m_sb | m_adr | m_btf);
    txs   = (ev_ack_tx & ~in_addr_phase) | ev_addr_done;
    rxs   = ev_ack_rx & ack_en;
    if (!enable) begin
      {m_sb, m_msl, m_adr, m_btf, m_rx, m_arm} = '0;
    end else begin
      sb_c  = m_arm & wr_data;
      btf_c = m_arm & (m_rx ? rd_data : wr_data);
      arm_n = rd_status ? 1'b1 : ((rd_data | wr_data) ? 1'b0 : m_arm);
      if (ev_start_done) m_sb = 1; else if (sb_c) m_sb = 0;
      if (start_req) m_msl = 1; else if (ev_stop | ev_arb_lost) m_msl = 0;
      if (ev_addr_match | ev_gen_call) m_adr = 1; else if (rd_status) m_adr = 0;
      if (txs | rxs) m_btf = 1; else if (btf_c) m_btf = 0;
      if (rxs) m_rx = 1; else if (txs) m_rx = 0;
      m_arm = arm_n;
    end
  endtask

  // one clock: inputs already set at a falling edge, compare at the next one
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 status vs model", int'(status), int'({m_btf, m_adr, m_msl, m_sb}));
    chk("R8 scl_hold vs model", int'(scl_hold), int'(m_btf | m_adr));
    chk("R10 irq vs model", int'(irq), int'(m_irq));
    {start_req, ev_start_done, ev_stop, ev_arb_lost, ev_addr_match, ev_gen_call,
     ev_ack_tx, ev_addr_done, ev_ack_rx, rd_status, rd_data, wr_data} = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset scl_hold", int'(scl_hold), 0);
    rst_n = 1'b1;
    enable = 1'b1; irq_en = 1'b1; ack_en = 1'b1;
    @(negedge clk);

    start_req = 1; cyc();
    chk("R3 msl set", int'(status[1]), 1);
    chk("R10 msl alone no irq", int'(irq), 0);
    ev_start_done = 1; cyc();
    chk("R2 sb set", int'(status[0]), 1);
    cyc();
    chk("R10 irq after sb", int'(irq), 1);
    wr_data = 1; cyc();
    chk("R7 unarmed write keeps sb", int'(status[0]), 1);
    rd_status = 1; cyc();
    chk("R2 read alone keeps sb", int'(status[0]), 1);
    wr_data = 1; cyc();
    chk("R2 armed write clears sb", int'(status[0]), 0);
    ev_arb_lost = 1; cyc();
    chk("R3 msl clear on arb lost", int'(status[1]), 0);

    ev_gen_call = 1; cyc();
    chk("R4 adsl set on general call", int'(status[2]), 1);
    chk("R8 scl_hold on adsl", int'(scl_hold), 1);
    rd_status = 1; ev_addr_match = 1; cyc();
    chk("R11 set wins over read clear", int'(status[2]), 1);
    rd_status = 1; cyc();
    chk("R4 read clears adsl", int'(status[2]), 0);
    chk("R8 scl released", int'(scl_hold), 0);

    ack_en = 0; ev_ack_rx = 1; cyc();
    chk("R6 no btf with ack off", int'(status[3]), 0);
    ack_en = 1; ev_ack_rx = 1; cyc();
    chk("R6 btf set on rx ack", int'(status[3]), 1);
    rd_status = 1; cyc(); wr_data = 1; cyc();
    chk("R6 rx btf kept on write", int'(status[3]), 1);
    rd_status = 1; cyc(); rd_data = 1; cyc();
    chk("R6 rx btf cleared on read", int'(status[3]), 0);

    in_addr_phase = 1; ev_ack_tx = 1; cyc();
    chk("R5 ack in address phase ignored", int'(status[3]), 0);
    ev_addr_done = 1; cyc();
    chk("R5 btf after address phase", int'(status[3]), 1);
    in_addr_phase = 0;
    rd_status = 1; cyc(); rd_data = 1; cyc();
    chk("R5 tx btf kept on read", int'(status[3]), 1);
    rd_status = 1; cyc(); rd_data = 1; cyc(); wr_data = 1; cyc();
    chk("R7 data access disarms", int'(status[3]), 1);
    rd_status = 1; cyc(); wr_data = 1; ev_ack_tx = 1; cyc();
    chk("R11 set wins over write clear", int'(status[3]), 1);
    rd_status = 1; cyc(); wr_data = 1; cyc();
    chk("R5 tx btf cleared on write", int'(status[3]), 0);

    start_req = 1; ev_addr_match = 1; cyc();
    enable = 0; ev_start_done = 1; ev_ack_rx = 1; cyc();
    chk("R9 disable clears flags", int'(status), 0);
    enable = 1; wr_data = 1; cyc();
    cyc();
    chk("R9 irq drops after disable", int'(irq), 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      enable = (r < 3) ? 1'b0 : 1'b1;
      if ($urandom_range(0, 15) == 0) irq_en = ~irq_en;
      if ($urandom_range(0, 15) == 0) ack_en = ~ack_en;
      if ($urandom_range(0, 7) == 0) in_addr_phase = ~in_addr_phase;
      start_req     = ($urandom_range(0, 19) == 0);
      ev_start_done = ($urandom_range(0, 19) == 0);
      ev_stop       = ($urandom_range(0, 24) == 0);
      ev_arb_lost   = ($urandom_range(0, 39) == 0);
      ev_addr_match = ($urandom_range(0, 24) == 0);
      ev_gen_call   = ($urandom_range(0, 39) == 0);
      ev_ack_tx     = ($urandom_range(0, 14) == 0);
      ev_addr_done  = ($urandom_range(0, 24) == 0);
      ev_ack_rx     = ($urandom_range(0, 14) == 0);
      case ($urandom_range(0, 5))
        0, 1: rd_status = 1;
        2:    rd_data = 1;
        3:    wr_data = 1;
        default: ;
      endcase
      cyc();
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule